// File: doc/BRIEF.md
# Page-Burst Pseudo-SRAM Read Sequencer

This block sits on the host side of an asynchronous SRAM-style pseudo-SRAM bus and turns a synchronous read request into the control waveform that the memory expects. A request carries a start word address, a word count of one to eight, and per-byte lane enables. The sequencer lowers chip enable and output enable and waits out one full random access. Within the same 8-word page it then steps only the low address bits, using the shorter page cycle. It returns each word with a one-cycle valid pulse and flags the final word.

Every analog limit is given in nanoseconds. The sequencer converts each limit to clock counts from a clock-period parameter, rounding up for minimums and down for maximums. A burst that runs past the end of a page is split: chip enable goes high for the minimum high time, and a new full random access opens the next page. The same split is forced whenever another page step would hold chip enable low longer than the page-hold ceiling. Write enable is held inactive, because the block only reads.

Top module: `psram_page_reader`

## Requirements
- R1: After reset, mem_ce_n, mem_oe_n and both mem_bs_n lanes are 1, rd_valid is 0 and req_ready is 1.
- R2: A request is taken on a clock where req_valid and req_ready are both 1. req_ready stays 0 until the burst has finished and mem_ce_n has been high for at least CP_CLK = 2 clocks. Every falling edge of mem_ce_n follows at least CP_CLK high clocks.
- R3: The first word of a burst (or of a new page) is presented FIRST_WAIT = 10 clocks after the edge that lowers mem_ce_n and applies the address: rd_valid=1 with rd_data for one cycle.
- R4: Each later word in the same page increments the address by one. The upper bits (above bit 2) stay the same, mem_ce_n stays low, and the word appears PAGE_WAIT = 4 clocks after the previous one.
- R5: req_len_m1 is the word count minus one (0..7). Exactly that many words plus one are returned, and rd_last=1 only with the final word.
- R6: When the next address has low bits 000, mem_ce_n rises after the current word. The next word then arrives CP_CLK+1+FIRST_WAIT = 13 clocks later, and mem_ce_n falls once per page touched. The address wraps modulo 2^22.
- R7: req_be bit 0 enables the lower byte (mem_bs_n[0], rd_data[7:0]) and bit 1 the upper byte. While mem_ce_n is low, a lane strobe is 0 exactly when its lane is enabled, and req_be=00 enables both lanes. A disabled lane returns 0 in rd_data.
- R8: mem_oe_n equals mem_ce_n at all times and mem_we_n is always 1.
- R9: mem_ce_n is never held low for more than PAGE_MAX_CLK = 500 clocks (4 µs). A page step that would exceed this is replaced by a split.
- R10: While mem_ce_n is low, mem_addr is held for at least PRC_CLK = 3 clocks between changes, and for the full first access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 22 | Start word address |
| req_len_m1 | input | 3 | Word count minus one |
| req_be | input | 2 | Byte lane enables, bit 0 lower |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | 16 | Read word, disabled lanes zero |
| rd_last | output | 1 | Final word of the burst |
| mem_addr | output | 22 | Memory word address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, held high |
| mem_bs_n | output | 2 | Byte lane strobes, active low, bit 0 lower |
| mem_dq | input | 16 | Read data from the memory |

## Verification
The hardest case to reach from the ports is a split in the middle of a burst, where a burst that starts near the end of a page must close chip enable, respect the high time and open a full access on the next page. The corner at the top of the address space, where the address wraps, is also hard to reach. Directed requests start at offsets 5 and 7 of a page and at the last two words of the address space. Random requests are biased so that about half of them start in the last three words of a page. A timing-aware memory model in the bench returns garbage whenever the address or chip enable has not been stable for the access time, so an early sample or a missed split shows up as a data mismatch.

// File: rtl/psram_rd_pkg.sv
package psram_rd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FIRST = 2'd1,
      ST_PAGE  = 2'd2,
      ST_GAP   = 2'd3
   } rd_state_e;

   // minimum limits: round up to whole clocks
   function automatic int ceil_clk(input int ns, input int clk_ps);
      return (ns * 1000 + clk_ps - 1) / clk_ps;
   endfunction

   // maximum limits: round down so the bound is never exceeded
   function automatic int floor_clk(input int ns, input int clk_ps);
      return (ns * 1000) / clk_ps;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/psram_rd_waitcnt.sv
module psram_rd_waitcnt #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] target,
   output logic          hit
);

   logic          running;
   logic [CW-1:0] cnt;

   assign hit = running && (cnt == target);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (start) begin
         running <= 1'b1;
         cnt     <= CW'(1);
      end else if (hit) begin
         running <= 1'b0;
      end else if (running) begin
         cnt <= cnt + CW'(1);
      end
   end

   AST_WAIT_NOT_PAST_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt <= target)); // R3

endmodule

// File: rtl/psram_rd_ce_guard.sv
module psram_rd_ce_guard #(
   parameter int PAGE_MAX_CLK = 500,
   parameter int PAGE_WAIT    = 4,
   parameter int CP_CLK       = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   output logic page_room,
   output logic gap_done
);

   localparam int LOW_W      = $clog2(PAGE_MAX_CLK + 1) + 1;
   localparam int HIGH_W     = $clog2(CP_CLK + 1) + 1;
   localparam int ROOM_LIMIT = PAGE_MAX_CLK - PAGE_WAIT - 1;

   logic [LOW_W-1:0]  lo_cnt;
   logic [HIGH_W-1:0] hi_cnt;

   generate
      if (ROOM_LIMIT < 0) begin : g_bad_room
         $error("page hold ceiling shorter than one page step");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         hi_cnt <= HIGH_W'(CP_CLK);
      end else if (ce_n) begin
         lo_cnt <= '0;
         if (hi_cnt != HIGH_W'(CP_CLK))
            hi_cnt <= hi_cnt + HIGH_W'(1);
      end else begin
         hi_cnt <= '0;
         if (lo_cnt != LOW_W'(PAGE_MAX_CLK))
            lo_cnt <= lo_cnt + LOW_W'(1);
      end
   end

   assign page_room = (lo_cnt <= LOW_W'(ROOM_LIMIT));
   assign gap_done  = (hi_cnt == HIGH_W'(CP_CLK));

   AST_CE_LOW_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_n |-> (lo_cnt < LOW_W'(PAGE_MAX_CLK))); // R9

   AST_CE_HIGH_BEFORE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ce_n) |-> ($past(hi_cnt) == HIGH_W'(CP_CLK))); // R2

endmodule

// File: rtl/psram_rd_lane.sv
module psram_rd_lane (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       en_in,
   input  logic       drive,
   input  logic       release_i,
   input  logic       cap,
   input  logic [7:0] dq_byte,
   output logic       strb_n,
   output logic [7:0] byte_q
);

   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         strb_n <= 1'b1;
         byte_q <= '0;
      end else begin
         if (load)
            en_q <= en_in;
         if (drive)
            strb_n <= !(load ? en_in : en_q);
         else if (release_i)
            strb_n <= 1'b1;
         if (cap)
            byte_q <= en_q ? dq_byte : 8'h00;
      end
   end

   AST_LANE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(strb_n) && !$past(release_i)) |-> !strb_n); // R7

endmodule

// File: rtl/psram_page_reader.sv
module psram_page_reader
   import psram_rd_pkg::*;
#(
   parameter int CLK_PS        = 8000,
   parameter int ADDR_W        = 22,
   parameter int DATA_W        = 16,
   parameter int PAGE_WORDS    = 8,
   parameter int MAX_WORDS     = 8,
   parameter int T_RC_NS       = 65,
   parameter int T_AA_NS       = 65,
   parameter int T_OE_NS       = 40,
   parameter int T_BA_NS       = 30,
   parameter int T_PRC_NS      = 20,
   parameter int T_PAA_NS      = 20,
   parameter int T_CP_NS       = 10,
   parameter int T_PAGE_MAX_NS = 4000,
   parameter int T_CYC_MAX_NS  = 1000,
   localparam int LANES        = DATA_W / 8,
   localparam int LEN_W        = $clog2(MAX_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len_m1,
   input  logic [LANES-1:0]  req_be,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_last,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_bs_n,
   input  logic [DATA_W-1:0] mem_dq
);

   localparam int OFS_W        = $clog2(PAGE_WORDS);
   localparam int RC_CLK       = ceil_clk(T_RC_NS, CLK_PS);
   localparam int AA_CLK       = ceil_clk(T_AA_NS, CLK_PS);
   localparam int OE_CLK       = ceil_clk(T_OE_NS, CLK_PS);
   localparam int BA_CLK       = ceil_clk(T_BA_NS, CLK_PS);
   localparam int PRC_CLK      = ceil_clk(T_PRC_NS, CLK_PS);
   localparam int PAA_CLK      = ceil_clk(T_PAA_NS, CLK_PS);
   localparam int CP_CLK       = ceil_clk(T_CP_NS, CLK_PS);
   localparam int PAGE_MAX_CLK = floor_clk(T_PAGE_MAX_NS, CLK_PS);
   localparam int CYC_MAX_CLK  = floor_clk(T_CYC_MAX_NS, CLK_PS);
   localparam int FIRST_WAIT   = max2(max2(RC_CLK, AA_CLK), max2(OE_CLK, BA_CLK)) + 1;
   localparam int PAGE_WAIT    = max2(PRC_CLK, PAA_CLK) + 1;
   localparam int WAIT_W       = $clog2(FIRST_WAIT + 1) + 1;

   // elaboration-time parameter checks
   generate
      if (DATA_W % 8 != 0 || LANES < 1) begin : g_bad_width
         $error("data width must be a whole number of bytes");
      end
      if (PAGE_WORDS < 2 || (PAGE_WORDS & (PAGE_WORDS - 1)) != 0) begin : g_bad_page
         $error("page size must be a power of two of at least 2");
      end
      if (MAX_WORDS < 2 || (MAX_WORDS & (MAX_WORDS - 1)) != 0) begin : g_bad_len
         $error("burst limit must be a power of two of at least 2");
      end
      if (FIRST_WAIT > CYC_MAX_CLK || PAGE_WAIT > CYC_MAX_CLK) begin : g_bad_cycle
         $error("an access cycle would exceed the single-cycle ceiling");
      end
      if (PAGE_MAX_CLK < FIRST_WAIT + PAGE_WAIT) begin : g_bad_hold
         $error("page hold ceiling too short for one full access and one step");
      end
      if (ADDR_W <= OFS_W) begin : g_bad_addr
         $error("address narrower than the page offset");
      end
   endgenerate

   rd_state_e           state;
   logic [LEN_W-1:0]    left_q;
   logic                hit;
   logic                page_room;
   logic                gap_done;
   logic                acc;
   logic                last;
   logic                crosses;
   logic                page_step;
   logic                split;
   logic                finish;
   logic                gap_exit;
   logic                timer_start;
   logic [WAIT_W-1:0]   wait_target;
   logic [ADDR_W-1:0]   next_addr;
   logic [LANES-1:0]    be_eff;

   assign mem_we_n    = 1'b1;
   assign req_ready   = (state == ST_IDLE) && gap_done;
   assign acc         = req_valid && req_ready;
   assign be_eff      = (req_be == '0) ? {LANES{1'b1}} : req_be;
   assign last        = (left_q == '0);
   assign next_addr   = mem_addr + ADDR_W'(1);
   assign crosses     = (next_addr[OFS_W-1:0] == '0);
   assign page_step   = hit && !last && !crosses && page_room;
   assign split       = hit && !last && !page_step;
   assign finish      = hit && last;
   assign gap_exit    = (state == ST_GAP) && gap_done;
   assign timer_start = acc || page_step || gap_exit;
   assign wait_target = (state == ST_PAGE) ? WAIT_W'(PAGE_WAIT) : WAIT_W'(FIRST_WAIT);

   psram_rd_waitcnt #(
      .CW (WAIT_W)
   ) u_wait (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (timer_start),
      .target (wait_target),
      .hit    (hit)
   );

   psram_rd_ce_guard #(
      .PAGE_MAX_CLK (PAGE_MAX_CLK),
      .PAGE_WAIT    (PAGE_WAIT),
      .CP_CLK       (CP_CLK)
   ) u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_n      (mem_ce_n),
      .page_room (page_room),
      .gap_done  (gap_done)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         psram_rd_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (acc),
            .en_in     (be_eff[g]),
            .drive     (acc || gap_exit),
            .release_i (finish || split),
            .cap       (hit),
            .dq_byte   (mem_dq[8*g +: 8]),
            .strb_n    (mem_bs_n[g]),
            .byte_q    (rd_data[8*g +: 8])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         mem_ce_n <= 1'b1;
         mem_oe_n <= 1'b1;
         mem_addr <= '0;
         left_q   <= '0;
         rd_valid <= 1'b0;
         rd_last  <= 1'b0;
      end else begin
         rd_valid <= hit;
         rd_last  <= finish;
         case (state)
            ST_IDLE: begin
               if (acc) begin
                  state    <= ST_FIRST;
                  mem_ce_n <= 1'b0;
                  mem_oe_n <= 1'b0;
                  mem_addr <= req_addr;
                  left_q   <= req_len_m1;
               end
            end
            ST_FIRST, ST_PAGE: begin
               if (finish) begin
                  state    <= ST_IDLE;
                  mem_ce_n <= 1'b1;
                  mem_oe_n <= 1'b1;
               end else if (hit) begin
                  mem_addr <= next_addr;
                  left_q   <= left_q - LEN_W'(1);
                  if (page_step) begin
                     state <= ST_PAGE;
                  end else begin
                     state    <= ST_GAP;
                     mem_ce_n <= 1'b1;
                     mem_oe_n <= 1'b1;
                  end
               end
            end
            ST_GAP: begin
               if (gap_done) begin
                  state    <= ST_FIRST;
                  mem_ce_n <= 1'b0;
                  mem_oe_n <= 1'b0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // address hold observer used by the checks below
   logic [ADDR_W-1:0] addr_seen;
   logic [WAIT_W-1:0] addr_age;
   logic              addr_chg;

   assign addr_chg = (mem_addr != addr_seen);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_seen <= '0;
         addr_age  <= '0;
      end else begin
         addr_seen <= mem_addr;
         if (addr_chg)
            addr_age <= '0;
         else if (addr_age != WAIT_W'(FIRST_WAIT))
            addr_age <= addr_age + WAIT_W'(1);
      end
   end

   AST_READY_ONLY_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> mem_ce_n); // R2

   AST_OE_FOLLOWS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_oe_n == mem_ce_n); // R8

   AST_SOME_LANE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !mem_oe_n) |-> !(&mem_bs_n)); // R7

   AST_UPPER_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !$past(mem_ce_n)) |->
         (mem_addr[ADDR_W-1:OFS_W] == $past(mem_addr[ADDR_W-1:OFS_W]))); // R4

   AST_ADDR_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && addr_chg && !$past(mem_ce_n)) |->
         (addr_age >= WAIT_W'(PRC_CLK - 1))); // R10

   AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> rd_valid); // R5

   AST_VALID_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R3

endmodule

// File: tb/psram_page_reader_bench.sv
module psram_page_reader_bench;

   localparam int ADDR_W       = 22;
   localparam int FIRST_WAIT   = 10;  // ceil(65 ns / 8 ns) + 1
   localparam int PAGE_WAIT    = 4;   // ceil(20 ns / 8 ns) + 1
   localparam int CP_CLK       = 2;   // ceil(10 ns / 8 ns)
   localparam int PAGE_MAX_CLK = 500; // 4 us / 8 ns
   localparam int AA_CLK       = 9;
   localparam int PAA_CLK      = 3;
   localparam int PRC_CLK      = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [2:0]        req_len_m1 = '0;
   logic [1:0]        req_be = '0;
   logic              rd_valid;
   logic [15:0]       rd_data;
   logic              rd_last;
   logic [ADDR_W-1:0] mem_addr;
   logic              mem_ce_n;
   logic              mem_oe_n;
   logic              mem_we_n;
   logic [1:0]        mem_bs_n;
   logic [15:0]       mem_dq;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   psram_page_reader u_psram_page_reader (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_addr   (req_addr),
      .req_len_m1 (req_len_m1),
      .req_be     (req_be),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .rd_last    (rd_last),
      .mem_addr   (mem_addr),
      .mem_ce_n   (mem_ce_n),
      .mem_oe_n   (mem_oe_n),
      .mem_we_n   (mem_we_n),
      .mem_bs_n   (mem_bs_n),
      .mem_dq     (mem_dq)
   );

   function automatic logic [15:0] pat(input logic [ADDR_W-1:0] a);
      return a[15:0] ^ {a[21:16], 10'h0} ^ 16'h3C96;
   endfunction

   function automatic logic [15:0] lane_mask(input logic [1:0] be);
      logic [1:0] e;
      e = (be == 2'b00) ? 2'b11 : be;
      return {{8{e[1]}}, {8{e[0]}}};
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // timing-aware memory model: data only after the access times
   logic [ADDR_W-1:0] m_last;
   logic              m_ce_prev = 1'b1;
   int                up_age = 0;
   int                lo_age = 0;
   wire               m_ok = !mem_ce_n && !mem_oe_n && up_age >= AA_CLK && lo_age >= PAA_CLK;
   assign mem_dq[7:0]  = (m_ok && !mem_bs_n[0]) ? pat(mem_addr)[7:0]  : 8'hEE;
   assign mem_dq[15:8] = (m_ok && !mem_bs_n[1]) ? pat(mem_addr)[15:8] : 8'hEE;

   // per-cycle observation of the bus
   logic [1:0] cur_be = 2'b11;
   int hi_run = 1000;
   int lo_run = 0;
   int ce_falls = 0;
   int addr_run = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_ce_n) begin
            up_age <= 0;
            lo_age <= 0;
         end else if (m_ce_prev || mem_addr[ADDR_W-1:3] != m_last[ADDR_W-1:3]) begin
            up_age <= 1;
            lo_age <= 1;
         end else if (mem_addr != m_last) begin
            lo_age <= 1;
            up_age <= (up_age < 255) ? up_age + 1 : up_age;
         end else begin
            lo_age <= (lo_age < 255) ? lo_age + 1 : lo_age;
            up_age <= (up_age < 255) ? up_age + 1 : up_age;
         end

         check(mem_we_n == 1'b1, "R8 we_n high", mem_we_n, 1);
         check(mem_oe_n == mem_ce_n, "R8 oe_n tracks ce_n", mem_oe_n, mem_ce_n);
         if (!mem_ce_n) begin
            check(mem_bs_n == ~((cur_be == 2'b00) ? 2'b11 : cur_be), "R7 lane strobes",
                  mem_bs_n, ~((cur_be == 2'b00) ? 2'b11 : cur_be));
            if (m_ce_prev) begin
               ce_falls <= ce_falls + 1;
               check(hi_run >= CP_CLK, "R2 ce high time", hi_run, CP_CLK);
               lo_run <= 1;
               addr_run <= 1;
            end else begin
               check(lo_run + 1 <= PAGE_MAX_CLK, "R9 ce low ceiling", lo_run + 1, PAGE_MAX_CLK);
               lo_run <= lo_run + 1;
               if (mem_addr != m_last) begin
                  check(addr_run >= PRC_CLK, "R10 address hold", addr_run, PRC_CLK);
                  check(mem_addr[ADDR_W-1:3] == m_last[ADDR_W-1:3], "R4 upper bits held",
                        mem_addr, m_last);
                  addr_run <= 1;
               end else begin
                  addr_run <= addr_run + 1;
               end
            end
            hi_run <= 0;
         end else begin
            hi_run <= hi_run + 1;
         end
         m_last    <= mem_addr;
         m_ce_prev <= mem_ce_n;
      end
   end

   task automatic do_req(input logic [ADDR_W-1:0] addr, input logic [2:0] len_m1,
                         input logic [1:0] be);
      int acc_cyc;
      int prev_cyc;
      int got;
      int falls0;
      int pages;
      int guard;
      logic [ADDR_W-1:0] a;
      guard = 0;
      @(negedge clk);
      while (!req_ready && guard < 100) begin
         guard++;
         @(negedge clk);
      end
      check(req_ready == 1'b1, "R2 ready returns", req_ready, 1);
      pages = 0;
      for (int i = 0; i <= int'(len_m1); i++) begin
         a = addr + ADDR_W'(i);
         if (i == 0 || a[2:0] == 3'd0) pages++;
      end
      falls0     = ce_falls;
      cur_be     = be;
      req_addr   = addr;
      req_len_m1 = len_m1;
      req_be     = be;
      req_valid  = 1'b1;
      acc_cyc    = cyc + 1;
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready == 1'b0, "R2 ready drops after accept", req_ready, 0);
      got = 0;
      prev_cyc = acc_cyc;
      guard = 0;
      while (got <= int'(len_m1) && guard < 400) begin
         guard++;
         if (rd_valid) begin
            a = addr + ADDR_W'(got);
            check(rd_data == (pat(a) & lane_mask(be)), "R7 R3 read data",
                  rd_data, pat(a) & lane_mask(be));
            if (got == 0)
               check(cyc - acc_cyc == FIRST_WAIT, "R3 first word latency",
                     cyc - acc_cyc, FIRST_WAIT);
            else if (a[2:0] == 3'd0)
               check(cyc - prev_cyc == CP_CLK + 1 + FIRST_WAIT, "R6 split latency",
                     cyc - prev_cyc, CP_CLK + 1 + FIRST_WAIT);
            else
               check(cyc - prev_cyc == PAGE_WAIT, "R4 page step latency",
                     cyc - prev_cyc, PAGE_WAIT);
            check(rd_last == (got == int'(len_m1)), "R5 last flag", rd_last,
                  got == int'(len_m1));
            if (got == int'(len_m1))
               check(req_ready == 1'b0, "R2 not ready at burst end", req_ready, 0);
            prev_cyc = cyc;
            got++;
         end
         @(negedge clk);
      end
      check(got == int'(len_m1) + 1, "R5 word count", got, int'(len_m1) + 1);
      repeat (2) @(negedge clk);
      check(ce_falls - falls0 == pages, "R6 ce falls per page", ce_falls - falls0, pages);
      check(rd_valid == 1'b0, "R5 no extra words", rd_valid, 0);
   endtask

   initial begin
      logic [ADDR_W-1:0] ra;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(mem_ce_n && mem_oe_n && mem_bs_n == 2'b11, "R1 bus idle in reset",
            {mem_ce_n, mem_oe_n, mem_bs_n}, 4'hF);
      rst_n = 1'b1;
      @(negedge clk);
      check(mem_ce_n && mem_oe_n && mem_bs_n == 2'b11, "R1 bus idle after reset",
            {mem_ce_n, mem_oe_n, mem_bs_n}, 4'hF);
      check(rd_valid == 1'b0, "R1 no valid after reset", rd_valid, 0);
      check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

      do_req(22'h000000, 3'd7, 2'b11);   // full aligned page
      do_req(22'h000005, 3'd7, 2'b01);   // R6 split mid-burst, lower lane
      do_req(22'h3FFFFE, 3'd3, 2'b00);   // R6 wrap, R7 both-zero enables
      do_req(22'h123457, 3'd1, 2'b10);   // split right after first word
      do_req(22'h0ABCD3, 3'd0, 2'b11);   // single word
      for (int n = 0; n < 60; n++) begin
         ra = ADDR_W'($urandom);
         if ($urandom_range(1, 0) == 1) ra[2:0] = 3'(5 + $urandom_range(2, 0));
         do_req(ra, 3'($urandom_range(7, 0)), 2'($urandom_range(3, 0)));
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule